// File: doc/BRIEF.md
# Reverse-Channel Transmit Block Framer

This block turns host-supplied data words into the serial bit stream of a block-oriented wireless data link. The host writes a word into a one-word holding buffer. The framer moves that word into its shift register and sends it least significant bit first, one bit per bit-rate enable. Each data bit is XORed with the output of a 7-bit scrambler. After every nine data bits the framer inserts a continuity bit, which carries the level the host presented when the word was taken. A new block begins on the first word after transmit powersave ends, or when the continuity level of a word is 1 and that of the previous word was 0. A new block starts with an alternating preamble followed by a block sync word. The scrambler is reseeded and the continuity count restarts at that point.

When a word has been fully sent, including any continuity bit that falls due after its last data bit, the framer raises the buffer-empty flag and pulses the interrupt. The host can write the next word while the current one is still going out. If the next word is already waiting when the current word finishes, it follows with no idle slot. The modulator and filtering that come after the framer are outside this block.

The control states are: `ST_OFF` (powersave), `ST_IDLE` (waiting for a word), `ST_DOT` (preamble), `ST_SYNC` (sync word), `ST_DATA` (scrambled data bit) and `ST_CI` (continuity bit). The transitions are:

- `ST_OFF` goes to `ST_IDLE` once powersave is low.
- `ST_IDLE` loads a word on a tick when the buffer is full. It goes to `ST_DOT` if a new block starts, otherwise to `ST_DATA`.
- `ST_DOT` goes to `ST_SYNC` after its last preamble bit.
- `ST_SYNC` goes to `ST_DATA` after its last sync bit.
- `ST_DATA` goes to `ST_CI` when the ninth data bit of a group is sent. After the last bit of a word, it finishes the word.
- `ST_CI` returns to `ST_DATA` if bits remain in the word, otherwise it finishes the word.
- Finishing a word either loads the waiting word (going to `ST_DOT` or `ST_DATA`) or goes to `ST_IDLE`.
- A high powersave input sends every state to `ST_OFF`.

Top module: `rctx_framer`

## Requirements
- R1: After reset, `tx_valid`, `txf` and `irq` are 0.
- R2: While `pwr_save` is high, `tx_valid` is 0 from the next clock onward. A word written during powersave is kept and is sent after exit.
- R3: The first word after powersave exit is preceded by 38 alternating bits starting with 1, then the 22-bit `SYNC_WORD` sent most significant bit first.
- R4: A word loaded with `ci_level`=1, when the previous word was loaded with `ci_level`=0, is preceded by the same preamble and sync word. No prefix is sent when the level stays the same or falls.
- R5: A data bit equals the word bit (sent from bit 0 upward) XOR the scrambler output, which is state bit 6. The scrambler state shifts left with new bit 0 = bit6 XOR bit5. It is set to 7'h7F at each prefix, advances only on data bits, and carries over across words and idle gaps within a block.
- R6: After every 9 data bits of a block, one bit equal to the word's sampled `ci_level` is sent. The count restarts at each prefix and carries over across words. A bit that falls due after a word's last data bit is sent before the next word.
- R7: If the buffer holds a word when the current word finishes, its prefix or first data bit is sent in the next bit slot with no invalid slot in between.
- R8: Finishing a word sets `txf`, and `irq` pulses high in the same cycle that `txf` rises. There is one pulse per word.
- R9: `txf` is cleared on the clock after `wr_en` or `irq_ack`. Setting it wins over clearing it in the same cycle.
- R10: `tx_bit` and `tx_valid` change only on clocks where `bit_en` is high, except that `tx_valid` drops in powersave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Single-cycle bit-rate tick |
| pwr_save | input | 1 | Transmit powersave request |
| wr_en | input | 1 | Host write strobe for the holding buffer |
| wr_data | input | WORD_W | Host data word |
| ci_level | input | 1 | Continuity level, sampled when a word is loaded |
| irq_ack | input | 1 | Host read of the interrupt flags; clears `txf` |
| tx_bit | output | 1 | Serial line bit |
| tx_valid | output | 1 | `tx_bit` carries a framed bit |
| txf | output | 1 | Buffer-empty flag |
| irq | output | 1 | One-cycle interrupt pulse on word finish |

## Verification
Several properties are checked on every clock:
- the outputs hold still between ticks;
- `tx_valid` goes quiet under powersave;
- `irq` only accompanies a set `txf` and marks each rise of it;
- host writes and acknowledges clear the flag unless a finish coincides.

The content and order of the stream can only be shown by the bench's scenarios. This covers the prefix placement on exit and on continuity rises, the scrambler seeding and carry-over, continuity bits landing at word ends, back-to-back words without gaps, and retention of a word written during powersave. The bench sweeps all 16 continuity patterns over four-word runs against an arithmetic model.

// File: rtl/rctx_pkg.sv
package rctx_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_IDLE = 3'd1,
        ST_DOT  = 3'd2,
        ST_SYNC = 3'd3,
        ST_DATA = 3'd4,
        ST_CI   = 3'd5
    } rctx_state_e;

    localparam int SCR_W = 7;

endpackage

// File: rtl/rctx_scrambler.sv
// Whitening sequence x^7 + x^6 + 1 (R5): output is state bit 6,
// state shifts left with bit6 ^ bit5 entering at bit 0.
module rctx_scrambler
    import rctx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic seed,
    input  logic adv,
    output logic sc_bit
);

    logic [SCR_W-1:0] st_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '1;
        end else if (seed) begin
            st_q <= '1;
        end else if (adv) begin
            st_q <= {st_q[SCR_W-2:0], st_q[SCR_W-1] ^ st_q[SCR_W-2]};
        end
    end

    assign sc_bit = st_q[SCR_W-1];

endmodule

// File: rtl/rctx_hostbuf.sv
// One-word holding buffer plus buffer-empty flag and interrupt pulse (R8, R9).
module rctx_hostbuf #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              take,
    input  logic              fin,
    input  logic              irq_ack,
    output logic [WORD_W-1:0] buf_word,
    output logic              buf_full,
    output logic              txf,
    output logic              irq
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_word <= '0;
            buf_full <= 1'b0;
        end else begin
            if (take && !wr_en) begin
                buf_full <= 1'b0;
            end
            if (wr_en) begin
                buf_word <= wr_data;
                buf_full <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txf <= 1'b0;
            irq <= 1'b0;
        end else begin
            irq <= fin;
            if (fin) begin
                txf <= 1'b1;
            end else if (wr_en || irq_ack) begin
                txf <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rctx_prefix_gen.sv
// Preamble / sync bit source (R3, R4): alternating bits starting at 1,
// then the sync word most significant bit first.
module rctx_prefix_gen #(
    parameter int                  CNT_W     = 6,
    parameter int                  SYNC_LEN  = 22,
    parameter logic [SYNC_LEN-1:0] SYNC_WORD = 22'h2D8F3A
) (
    input  logic             in_sync,
    input  logic [CNT_W-1:0] idx,
    output logic             pfx_bit
);

    logic sync_bit;

    always_comb begin
        sync_bit = 1'b0;
        for (int k = 0; k < SYNC_LEN; k++) begin
            if (idx == CNT_W'(k)) begin
                sync_bit = SYNC_WORD[SYNC_LEN-1-k];
            end
        end
    end

    assign pfx_bit = in_sync ? sync_bit : ~idx[0];

endmodule

// File: rtl/rctx_framer.sv
module rctx_framer
    import rctx_pkg::*;
#(
    parameter int                  WORD_W    = 16,
    parameter int                  CI_PERIOD = 9,
    parameter int                  DOT_LEN   = 38,
    parameter int                  SYNC_LEN  = 22,
    parameter logic [SYNC_LEN-1:0] SYNC_WORD = 22'h2D8F3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              pwr_save,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              ci_level,
    input  logic              irq_ack,
    output logic              tx_bit,
    output logic              tx_valid,
    output logic              txf,
    output logic              irq
);

    localparam int PFX_MAX = (DOT_LEN > SYNC_LEN) ? DOT_LEN : SYNC_LEN;
    localparam int CNT_W   = $clog2(PFX_MAX);
    localparam int BL_W    = $clog2(WORD_W + 1);
    localparam int CC_W    = $clog2(CI_PERIOD);

    localparam logic [CNT_W-1:0] DOT_LAST  = CNT_W'(DOT_LEN - 1);
    localparam logic [CNT_W-1:0] SYNC_LAST = CNT_W'(SYNC_LEN - 1);
    localparam logic [BL_W-1:0]  BL_FULL   = BL_W'(WORD_W);
    localparam logic [BL_W-1:0]  BL_ONE    = BL_W'(1);
    localparam logic [CC_W-1:0]  CC_LAST   = CC_W'(CI_PERIOD - 1);

    rctx_state_e       state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BL_W-1:0]   bl_q, bl_d;
    logic [CC_W-1:0]   cc_q, cc_d;
    logic [WORD_W-1:0] sh_q, sh_d;
    logic              wci_q, wci_d;
    logic              pci_q, pci_d;
    logic              first_q, first_d;

    logic              take, fin, seed, adv;
    logic              do_load, do_fin;
    logic [WORD_W-1:0] buf_word;
    logic              buf_full;
    logic              sc_bit;
    logic              pfx_bit;
    logic              in_frame;
    logic              emit_bit;

    rctx_hostbuf #(
        .WORD_W (WORD_W)
    ) u_hostbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .take     (take),
        .fin      (fin),
        .irq_ack  (irq_ack),
        .buf_word (buf_word),
        .buf_full (buf_full),
        .txf      (txf),
        .irq      (irq)
    );

    rctx_scrambler u_scr (
        .clk    (clk),
        .rst_n  (rst_n),
        .seed   (seed),
        .adv    (adv),
        .sc_bit (sc_bit)
    );

    rctx_prefix_gen #(
        .CNT_W     (CNT_W),
        .SYNC_LEN  (SYNC_LEN),
        .SYNC_WORD (SYNC_WORD)
    ) u_pfx (
        .in_sync (state_q == ST_SYNC),
        .idx     (cnt_q),
        .pfx_bit (pfx_bit)
    );

    // Next state and datapath updates.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        bl_d    = bl_q;
        cc_d    = cc_q;
        sh_d    = sh_q;
        wci_d   = wci_q;
        pci_d   = pci_q;
        first_d = first_q;
        take    = 1'b0;
        fin     = 1'b0;
        seed    = 1'b0;
        adv     = 1'b0;
        do_load = 1'b0;
        do_fin  = 1'b0;

        unique case (state_q)
            ST_OFF: begin
                if (!pwr_save) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (bit_en && buf_full) begin
                    do_load = 1'b1;
                end
            end
            ST_DOT: begin
                if (bit_en) begin
                    if (cnt_q == DOT_LAST) begin
                        state_d = ST_SYNC;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_SYNC: begin
                if (bit_en) begin
                    if (cnt_q == SYNC_LAST) begin
                        state_d = ST_DATA;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (bit_en) begin
                    adv  = 1'b1;
                    sh_d = sh_q >> 1;
                    bl_d = bl_q - 1'b1;
                    if (cc_q == CC_LAST) begin
                        // R6: continuity slot before anything else
                        cc_d    = '0;
                        state_d = ST_CI;
                    end else begin
                        cc_d = cc_q + 1'b1;
                        if (bl_q == BL_ONE) begin
                            do_fin = 1'b1;
                        end
                    end
                end
            end
            ST_CI: begin
                if (bit_en) begin
                    if (bl_q == '0) begin
                        do_fin = 1'b1;
                    end else begin
                        state_d = ST_DATA;
                    end
                end
            end
            default: begin
                state_d = ST_OFF;
            end
        endcase

        // Word finished: flag it and chain the waiting word (R7, R8).
        if (do_fin) begin
            fin = 1'b1;
            if (buf_full) begin
                do_load = 1'b1;
            end else begin
                state_d = ST_IDLE;
            end
        end

        // Word load: new block on powersave exit or continuity rise (R3, R4).
        if (do_load) begin
            take    = 1'b1;
            sh_d    = buf_word;
            bl_d    = BL_FULL;
            wci_d   = ci_level;
            pci_d   = ci_level;
            first_d = 1'b0;
            if (first_q || (ci_level && !pci_q)) begin
                state_d = ST_DOT;
                cnt_d   = '0;
                cc_d    = '0;
                seed    = 1'b1;
            end else begin
                state_d = ST_DATA;
            end
        end

        // Powersave overrides everything (R2).
        if (pwr_save) begin
            state_d = ST_OFF;
            first_d = 1'b1;
            take    = 1'b0;
            fin     = 1'b0;
            seed    = 1'b0;
            adv     = 1'b0;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            bl_q    <= '0;
            cc_q    <= '0;
            sh_q    <= '0;
            wci_q   <= 1'b0;
            pci_q   <= 1'b0;
            first_q <= 1'b1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            bl_q    <= bl_d;
            cc_q    <= cc_d;
            sh_q    <= sh_d;
            wci_q   <= wci_d;
            pci_q   <= pci_d;
            first_q <= first_d;
        end
    end

    // Bit selection for the current state (R5, R6).
    always_comb begin
        in_frame = 1'b0;
        emit_bit = 1'b0;
        unique case (state_q)
            ST_DOT, ST_SYNC: begin
                in_frame = 1'b1;
                emit_bit = pfx_bit;
            end
            ST_DATA: begin
                in_frame = 1'b1;
                emit_bit = sh_q[0] ^ sc_bit;
            end
            ST_CI: begin
                in_frame = 1'b1;
                emit_bit = wci_q;
            end
            default: begin
                in_frame = 1'b0;
                emit_bit = 1'b0;
            end
        endcase
    end

    // Output register: moves only on ticks (R10), quiet in powersave (R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_bit   <= 1'b0;
            tx_valid <= 1'b0;
        end else if (pwr_save) begin
            tx_valid <= 1'b0;
        end else if (bit_en) begin
            tx_valid <= in_frame;
            tx_bit   <= in_frame ? emit_bit : 1'b0;
        end
    end

endmodule

// File: rtl/rctx_framer_chk.sv
module rctx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic pwr_save,
    input logic wr_en,
    input logic irq_ack,
    input logic tx_bit,
    input logic tx_valid,
    input logic txf,
    input logic irq
);

    assert_quiet_in_powersave_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_save |=> !tx_valid);

    assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !pwr_save) |=> ($stable(tx_bit) && $stable(tx_valid)));

    assert_irq_with_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> txf);

    assert_flag_rise_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txf) |-> irq);

    assert_host_clears_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en || irq_ack) |=> (!txf || irq));

endmodule

bind rctx_framer rctx_framer_chk u_chk (.*);

// File: tb/rctx_framer_bench.sv
`timescale 1ns/1ps
module rctx_framer_bench;

    localparam int                 WW   = 16;
    localparam int                 CIP  = 9;
    localparam int                 DOTL = 38;
    localparam int                 SYL  = 22;
    localparam logic [SYL-1:0]     SYW  = 22'h2D8F3A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_en = 1'b0;
    logic          pwr_save = 1'b1;
    logic          wr_en = 1'b0;
    logic [WW-1:0] wr_data = '0;
    logic          ci_level = 1'b0;
    logic          irq_ack = 1'b0;
    logic          tx_bit, tx_valid, txf, irq;

    int checks = 0;
    int errors = 0;

    rctx_framer #(
        .WORD_W(WW), .CI_PERIOD(CIP), .DOT_LEN(DOTL), .SYNC_LEN(SYL), .SYNC_WORD(SYW)
    ) u_rctx_framer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pwr_save(pwr_save),
        .wr_en(wr_en), .wr_data(wr_data), .ci_level(ci_level), .irq_ack(irq_ack),
        .tx_bit(tx_bit), .tx_valid(tx_valid), .txf(txf), .irq(irq)
    );

    always #4 clk = ~clk;

    // Collector and tick generator.
    bit act_q[$];
    int gaps = 0;
    bit watch = 0;
    int irq_cnt = 0;
    int div = 0;

    always @(negedge clk) begin
        if (bit_en) begin
            if (tx_valid) act_q.push_back(tx_bit);
            else if (watch && act_q.size() > 0) gaps++;
        end
        if (irq) irq_cnt++;
        div = (div + 1) % 4;
        bit_en = (div == 3);
    end

    // Reference model.
    bit         exp_q[$];
    int         exp_r[$];
    logic [6:0] m_lfsr;
    int         m_cic;
    bit         m_prev;
    bit         m_first;

    task automatic m_push(input bit b, input int r);
        exp_q.push_back(b);
        exp_r.push_back(r);
    endtask

    task automatic m_word(input logic [WW-1:0] w, input bit c);
        if (m_first || (c && !m_prev)) begin
            for (int i = 0; i < DOTL; i++) m_push((i % 2) == 0, 3);   // R3 preamble
            for (int i = 0; i < SYL; i++) m_push(SYW[SYL-1-i], 3);    // R3 sync word
            m_lfsr = 7'h7F;
            m_cic  = 0;
        end
        m_first = 0;
        m_prev  = c;
        for (int i = 0; i < WW; i++) begin
            m_push(w[i] ^ m_lfsr[6], 5);                              // R5
            m_lfsr = {m_lfsr[5:0], m_lfsr[6] ^ m_lfsr[5]};
            m_cic++;
            if (m_cic == CIP) begin
                m_push(c, 6);                                         // R6
                m_cic = 0;
            end
        end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cmp_stream(input string tag);
        int n;
        n = (act_q.size() < exp_q.size()) ? act_q.size() : exp_q.size();
        check(act_q.size() == exp_q.size(), {tag, " stream length R3 R6"}, act_q.size(), exp_q.size());
        for (int i = 0; i < n; i++) begin
            checks++;
            if (act_q[i] !== exp_q[i]) begin
                errors++;
                $display("FAIL R%0d %s bit %0d actual=%0b expected=%0b",
                         exp_r[i], tag, i, act_q[i], exp_q[i]);
            end
        end
    endtask

    task automatic host_write(input logic [WW-1:0] w, input bit c);
        @(negedge clk);
        ci_level = c;
        wr_data  = w;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check(txf == 1'b0, "R9 write clears txf", txf, 0);
    endtask

    task automatic wait_txf();
        do @(negedge clk); while (!txf);
    endtask

    task automatic run_pattern(input int p);
        logic [WW-1:0] w[4];
        bit            c[4];
        for (int k = 0; k < 4; k++) begin
            w[k] = WW'(p * 16'h1357 + k * 16'h9E37 + 16'h00A5);
            c[k] = p[k];
        end
        if (p == 0) w[0] = '0;
        if (p == 15) w[1] = '1;
        pwr_save = 1'b1;
        repeat (4) @(negedge clk);
        check(tx_valid == 1'b0, "R2 powersave quiet", tx_valid, 0);
        act_q.delete(); exp_q.delete(); exp_r.delete();
        gaps = 0; irq_cnt = 0; m_first = 1;
        for (int k = 0; k < 4; k++) m_word(w[k], c[k]);
        @(negedge clk);
        pwr_save = 1'b0;
        host_write(w[0], c[0]);
        while (act_q.size() == 0) @(negedge clk);
        watch = 1;
        host_write(w[1], c[1]);
        wait_txf();
        host_write(w[2], c[2]);
        wait_txf();
        watch = 0;
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check(txf == 1'b0, "R9 irq_ack clears txf", txf, 0);
        wait_txf();
        repeat (20) @(negedge clk);
        host_write(w[3], c[3]);
        wait_txf();
        repeat (8) @(negedge clk);
        cmp_stream($sformatf("pattern %0d", p));
        check(gaps == 0, "R7 back-to-back no gap", gaps, 0);
        check(irq_cnt == 4, "R8 one irq per word", irq_cnt, 4);
        check(txf == 1'b1, "R8 txf set after finish", txf, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(tx_valid == 1'b0, "R1 reset tx_valid", tx_valid, 0);
        check(txf == 1'b0, "R1 reset txf", txf, 0);
        check(irq == 1'b0, "R1 reset irq", irq, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(tx_valid == 1'b0 && txf == 1'b0 && irq == 1'b0, "R1 after release", tx_valid, 0);

        // Sweep every continuity pattern over four words (R3 R4 R5 R6 R7).
        for (int p = 0; p < 16; p++) run_pattern(p);

        // Powersave mid-word, word written in powersave retained (R2 R3).
        host_write(16'hC3A5, 1'b0);
        act_q.delete();
        while (act_q.size() < 10) @(negedge clk);
        pwr_save = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check(tx_valid == 1'b0, "R2 dropped in powersave", tx_valid, 0);
        end
        host_write(16'h5A0F, 1'b1);
        repeat (8) @(negedge clk);
        check(tx_valid == 1'b0, "R2 no output with held word", tx_valid, 0);
        act_q.delete(); exp_q.delete(); exp_r.delete();
        irq_cnt = 0; m_first = 1;
        m_word(16'h5A0F, 1'b1);
        pwr_save = 1'b0;
        wait_txf();
        repeat (8) @(negedge clk);
        cmp_stream("powersave exit");
        check(irq_cnt == 1, "R8 irq after retained word", irq_cnt, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule